// File: doc/BRIEF.md
# Floating-Point Compare Flag Unit

This block compares two double-precision floating-point operands by numeric value and sets a registered condition-flag word. The outcome is held in three flags: zero, parity and carry. Each of the four outcomes has its own pattern: less, equal, greater and unordered. The unordered pattern sets all three flags. As a result, a test that looks only at the zero flag cannot tell a NaN operand from a true equality. The block also raises an invalid-operation output when either operand is a signaling NaN.

A small branch-condition evaluator reads the held flags and reports whether a selected branch condition is taken. In its normal mode it checks the parity flag before it trusts the zero or carry flag. In a NaN-oblivious mode it treats parity as clear, which shows how an unordered compare turns into a false "equal". The condition select and the mode are live inputs, so one stored compare can be queried under every condition.

Top module: `fcmp_flag_unit`

## Requirements
- R1: When either operand is a NaN (exponent all ones, fraction nonzero), the result is unordered and sets zero, parity and carry to 1.
- R2: When the first operand is numerically greater than the second, zero, parity and carry are all 0.
- R3: When the first operand is numerically less than the second, only carry is 1.
- R4: When the operands are numerically equal, only zero is 1. Positive zero and negative zero are equal.
- R5: Ordering follows numeric value rather than raw bit patterns. This holds for negative values, subnormals and infinities.
- R6: `invalid_op` is 1 only when an operand is a signaling NaN, meaning exponent all ones, fraction nonzero and fraction bit 51 equal to 0. A quiet NaN gives unordered flags with `invalid_op` at 0.
- R7: The flag word layout is bit 0 carry, bit 1 parity, bit 2 auxiliary carry, bit 3 zero, bit 4 sign, bit 5 overflow. Bits 2, 4 and 5 are always 0.
- R8: Flags and `invalid_op` update, and `out_valid` is 1, in the cycle after a clock edge that samples `in_valid` high. After an edge with `in_valid` low, `out_valid` is 0 and the flags hold.
- R9: A synchronous active-high reset clears `out_valid`, the flag word and `invalid_op`.
- R10: In normal mode (`nan_oblivious`=0), `taken` follows `cond_sel` as listed here, and every code except 1, 6 and 7 is false on unordered:
  - 0: equal
  - 1: not equal, including unordered
  - 2: below
  - 3: below or equal
  - 4: above
  - 5: above or equal
  - 6: unordered
  - 7: ordered
- R11: With `nan_oblivious`=1, parity is treated as 0. An unordered compare then reads as equal, below and below-or-equal. It does not read as unordered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands are presented this cycle |
| op_a | input | 64 | First operand, double precision |
| op_b | input | 64 | Second operand, double precision |
| cond_sel | input | 3 | Branch condition code (R10) |
| nan_oblivious | input | 1 | Evaluator ignores the parity flag |
| out_valid | output | 1 | A compare result was registered on the last edge |
| flags | output | 6 | Condition-flag word (R7 layout) |
| invalid_op | output | 1 | A signaling NaN was compared |
| taken | output | 1 | Selected condition holds on the stored flags |

## Verification
Three outputs are registered: the flag word, `invalid_op` and `out_valid`. They are due at the first falling edge after the rising edge that samples `in_valid`. The bench drives operands at one falling edge and reads these outputs at the next falling edge. `taken` is combinational from the stored flags and the live select and mode. The bench therefore holds `in_valid` low, changes `cond_sel` at a falling edge and reads `taken` one nanosecond later, well before the next rising edge. These idle cycles also confirm that `out_valid` drops and the flags hold.

// File: rtl/fcmp_pkg.sv
`timescale 1ns/1ps
package fcmp_pkg;

    localparam int EXP_W_DEF  = 11;
    localparam int FRAC_W_DEF = 52;

    // Flag word, MSB first: overflow, sign, zero, aux-carry, parity, carry
    typedef struct packed {
        logic of;
        logic sf;
        logic zf;
        logic af;
        logic pf;
        logic cf;
    } flags_t;

    typedef enum logic [1:0] {
        REL_GT = 2'd0,
        REL_LT = 2'd1,
        REL_EQ = 2'd2,
        REL_UN = 2'd3
    } rel_e;

    typedef enum logic [2:0] {
        C_EQ = 3'd0,
        C_NE = 3'd1,
        C_BL = 3'd2,
        C_BE = 3'd3,
        C_AB = 3'd4,
        C_AE = 3'd5,
        C_UN = 3'd6,
        C_OR = 3'd7
    } cond_e;

    function automatic flags_t rel_to_flags(input rel_e r);
        flags_t f;
        f = '0;
        case (r)
            REL_UN: begin f.zf = 1'b1; f.pf = 1'b1; f.cf = 1'b1; end
            REL_LT: f.cf = 1'b1;
            REL_EQ: f.zf = 1'b1;
            default: f = '0;
        endcase
        return f;
    endfunction

endpackage

// File: rtl/fcmp_classify.sv
`timescale 1ns/1ps
module fcmp_classify #(
    parameter int EXP_W  = fcmp_pkg::EXP_W_DEF,
    parameter int FRAC_W = fcmp_pkg::FRAC_W_DEF,
    localparam int W     = 1 + EXP_W + FRAC_W
) (
    input  logic [W-1:0] val,
    output logic         sign,
    output logic         is_nan,
    output logic         is_snan,
    output logic         is_zero,
    output logic [W-2:0] mag
);
    logic [EXP_W-1:0]  expo;
    logic [FRAC_W-1:0] frac;

    assign sign    = val[W-1];
    assign expo    = val[W-2:FRAC_W];
    assign frac    = val[FRAC_W-1:0];
    assign mag     = val[W-2:0];
    assign is_nan  = (&expo) && (|frac);
    assign is_snan = is_nan && !frac[FRAC_W-1];
    assign is_zero = (mag == '0);
endmodule

// File: rtl/fcmp_order.sv
`timescale 1ns/1ps
module fcmp_order
    import fcmp_pkg::*;
#(
    parameter int MAG_W = 63
) (
    input  logic             sign_a,
    input  logic             nan_a,
    input  logic             zero_a,
    input  logic [MAG_W-1:0] mag_a,
    input  logic             sign_b,
    input  logic             nan_b,
    input  logic             zero_b,
    input  logic [MAG_W-1:0] mag_b,
    output rel_e             rel
);
    logic mag_gt;
    assign mag_gt = (mag_a > mag_b);

    always_comb begin
        if (nan_a || nan_b)
            rel = REL_UN;
        else if (zero_a && zero_b)
            rel = REL_EQ;
        else if (sign_a != sign_b)
            rel = sign_a ? REL_LT : REL_GT;
        else if (mag_a == mag_b)
            rel = REL_EQ;
        else
            rel = (mag_gt ^ sign_a) ? REL_GT : REL_LT;
    end
endmodule

// File: rtl/fcmp_cond_eval.sv
`timescale 1ns/1ps
module fcmp_cond_eval
    import fcmp_pkg::*;
(
    input  logic  zf,
    input  logic  pf,
    input  logic  cf,
    input  cond_e sel,
    input  logic  oblivious,
    output logic  taken
);
    logic p_eff;
    assign p_eff = pf && !oblivious;

    always_comb begin
        case (sel)
            C_EQ:    taken = !p_eff && zf;
            C_NE:    taken = p_eff || !zf;
            C_BL:    taken = !p_eff && cf;
            C_BE:    taken = !p_eff && (cf || zf);
            C_AB:    taken = !cf && !zf;
            C_AE:    taken = !cf;
            C_UN:    taken = p_eff;
            default: taken = !p_eff;
        endcase
    end
endmodule

// File: rtl/fcmp_flag_unit.sv
`timescale 1ns/1ps
module fcmp_flag_unit
    import fcmp_pkg::*;
#(
    parameter int EXP_W  = EXP_W_DEF,
    parameter int FRAC_W = FRAC_W_DEF,
    localparam int W     = 1 + EXP_W + FRAC_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         in_valid,
    input  logic [W-1:0] op_a,
    input  logic [W-1:0] op_b,
    input  logic [2:0]   cond_sel,
    input  logic         nan_oblivious,
    output logic         out_valid,
    output logic [5:0]   flags,
    output logic         invalid_op,
    output logic         taken
);
    logic [1:0][W-1:0] ops;
    logic [1:0]        sgn, nan, snan, zro;
    logic [1:0][W-2:0] mag;
    rel_e              rel;
    flags_t            flags_q;
    logic              valid_q, inv_q;

    assign ops = {op_b, op_a};

    for (genvar g = 0; g < 2; g++) begin : g_cls
        fcmp_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cls (
            .val     (ops[g]),
            .sign    (sgn[g]),
            .is_nan  (nan[g]),
            .is_snan (snan[g]),
            .is_zero (zro[g]),
            .mag     (mag[g])
        );
    end

    fcmp_order #(.MAG_W(W-1)) u_ord (
        .sign_a (sgn[0]), .nan_a (nan[0]), .zero_a (zro[0]), .mag_a (mag[0]),
        .sign_b (sgn[1]), .nan_b (nan[1]), .zero_b (zro[1]), .mag_b (mag[1]),
        .rel    (rel)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            flags_q <= '0;
            inv_q   <= 1'b0;
        end else begin
            valid_q <= in_valid;
            if (in_valid) begin
                flags_q <= rel_to_flags(rel);
                inv_q   <= |snan;
            end
        end
    end

    fcmp_cond_eval u_eval (
        .zf        (flags_q.zf),
        .pf        (flags_q.pf),
        .cf        (flags_q.cf),
        .sel       (cond_e'(cond_sel)),
        .oblivious (nan_oblivious),
        .taken     (taken)
    );

    assign out_valid  = valid_q;
    assign flags      = flags_q;
    assign invalid_op = inv_q;

    // R8: result due one cycle after the strobe
    a_r8_latency: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    // R8: no strobe leaves the flags unchanged
    a_r8_hold: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_valid && $stable(flags)));
    // R1: parity only ever appears with zero and carry
    a_r1_unordered: assert property (@(posedge clk) disable iff (rst)
        flags[1] |-> (flags[3] && flags[0]));
    // R4: equal and less never coexist on an ordered result
    a_r4_excl: assert property (@(posedge clk) disable iff (rst)
        (flags[3] && flags[0]) |-> flags[1]);
    // R6: invalid only accompanies an unordered result
    a_r6_snan_unord: assert property (@(posedge clk) disable iff (rst)
        invalid_op |-> flags[1]);
    // R7: reserved flags stay low
    a_r7_reserved: assert property (@(posedge clk) disable iff (rst)
        (flags[5] == 1'b0) && (flags[4] == 1'b0) && (flags[2] == 1'b0));
    // R11: oblivious equality test is fooled by unordered
    a_r11_fooled: assert property (@(posedge clk) disable iff (rst)
        (nan_oblivious && flags[1] && cond_sel == 3'd0) |-> taken);
endmodule

// File: tb/sim_fcmp_flag_unit.sv
`timescale 1ns/1ps
module sim_fcmp_flag_unit;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [63:0] op_a = '0, op_b = '0;
    logic [2:0]  cond_sel = '0;
    logic        nan_oblivious = 1'b0;
    logic        out_valid, invalid_op, taken;
    logic [5:0]  flags;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    fcmp_flag_unit u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
        .cond_sel(cond_sel), .nan_oblivious(nan_oblivious),
        .out_valid(out_valid), .flags(flags), .invalid_op(invalid_op), .taken(taken)
    );

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h (a=%h b=%h sel=%0d obl=%0d)",
                     req, act, exp, op_a, op_b, cond_sel, nan_oblivious);
        end
    endtask

    function automatic logic [63:0] val(input int k);
        case (k)
            0:  return 64'h0000_0000_0000_0000;
            1:  return 64'h8000_0000_0000_0000;
            2:  return 64'h0000_0000_0000_0001;
            3:  return 64'h8000_0000_0000_0001;
            4:  return 64'h000F_FFFF_FFFF_FFFF;
            5:  return 64'h3FF0_0000_0000_0000;
            6:  return 64'hBFF0_0000_0000_0000;
            7:  return 64'h3FF8_0000_0000_0000;
            8:  return 64'hBFF8_0000_0000_0000;
            9:  return 64'h7FEF_FFFF_FFFF_FFFF;
            10: return 64'hFFEF_FFFF_FFFF_FFFF;
            11: return 64'h7FF0_0000_0000_0000;
            12: return 64'hFFF0_0000_0000_0000;
            13: return 64'h7FF8_0000_0000_0000;
            14: return 64'h7FF0_0000_0000_0001;
            default: return 64'hFFF4_0000_0000_0000;
        endcase
    endfunction

    function automatic bit is_nan(input logic [63:0] v);
        return (v[62:52] == 11'h7FF) && (v[51:0] != 0);
    endfunction

    // 0 gt, 1 lt, 2 eq, 3 unordered
    function automatic int relation(input logic [63:0] a, input logic [63:0] b);
        real ra, rb;
        if (is_nan(a) || is_nan(b)) return 3;
        ra = $bitstoreal(a);
        rb = $bitstoreal(b);
        if (ra > rb) return 0;
        if (ra < rb) return 1;
        return 2;
    endfunction

    function automatic logic [5:0] exp_flags(input int r);
        case (r)
            0: return 6'b000000;
            1: return 6'b000001;
            2: return 6'b001000;
            default: return 6'b001011;
        endcase
    endfunction

    function automatic bit exp_taken(input int r, input int sel, input bit obl);
        bit un, eq, lt, gt;
        un = (r == 3);
        eq = (r == 2) || (un && obl);
        lt = (r == 1) || (un && obl);
        gt = (r == 0);
        if (un && obl) un = 1'b0;
        case (sel)
            0: return eq;
            1: return !eq;
            2: return lt;
            3: return lt || eq;
            4: return gt;
            5: return !un && (gt || eq) && !lt;
            6: return un;
            default: return !un;
        endcase
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        // R9: reset state
        check(out_valid == 1'b0, "R9 out_valid", {63'd0, out_valid}, 64'd0);
        check(flags == 6'd0, "R9 flags", {58'd0, flags}, 64'd0);
        check(invalid_op == 1'b0, "R9 invalid_op", {63'd0, invalid_op}, 64'd0);
        rst = 1'b0;

        for (int i = 0; i < 16; i++) begin
            for (int j = 0; j < 16; j++) begin
                int r;
                bit sn;
                @(negedge clk);
                op_a = val(i);
                op_b = val(j);
                in_valid = 1'b1;
                r = relation(op_a, op_b);
                sn = (is_nan(op_a) && !op_a[51]) || (is_nan(op_b) && !op_b[51]);
                @(negedge clk);
                in_valid = 1'b0;
                // R8: registered result one cycle after the strobe
                check(out_valid == 1'b1, "R8 out_valid", {63'd0, out_valid}, 64'd1);
                // R1 R2 R3 R4 R5 R7: flag pattern per numeric relation
                check(flags == exp_flags(r),
                      (r == 3) ? "R1 unordered" : (r == 0) ? "R2 greater" :
                      (r == 1) ? "R3 less R5" : "R4 equal R5",
                      {58'd0, flags}, {58'd0, exp_flags(r)});
                check(invalid_op == sn, "R6 signaling", {63'd0, invalid_op}, {63'd0, sn});
                for (int m = 0; m < 16; m++) begin
                    @(negedge clk);
                    cond_sel = m[2:0];
                    nan_oblivious = m[3];
                    #1;
                    if (m == 0) begin
                        // R8: idle cycle drops valid, flags hold
                        check(out_valid == 1'b0, "R8 idle", {63'd0, out_valid}, 64'd0);
                        check(flags == exp_flags(r), "R8 hold", {58'd0, flags}, {58'd0, exp_flags(r)});
                    end
                    check(taken == exp_taken(r, m % 8, m[3]),
                          m[3] ? "R11 oblivious" : "R10 strict",
                          {63'd0, taken}, {63'd0, exp_taken(r, m % 8, m[3])});
                end
            end
        end

        // R9: reset clears a held unordered/signaling result
        @(negedge clk);
        op_a = val(14); op_b = val(5); in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check(invalid_op == 1'b1, "R6 before reset", {63'd0, invalid_op}, 64'd1);
        rst = 1'b1;
        @(negedge clk);
        check(flags == 6'd0, "R9 flags cleared", {58'd0, flags}, 64'd0);
        check(invalid_op == 1'b0, "R9 invalid cleared", {63'd0, invalid_op}, 64'd0);
        check(out_valid == 1'b0, "R9 valid cleared", {63'd0, out_valid}, 64'd0);
        rst = 1'b0;
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #1200000;
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule